// File: doc/BRIEF.md
# Frame-Paced Interrupt Flag Register

This block gathers single-cycle event pulses into a register of interrupt flags and drives an active-low interrupt request line for a host processor. Events are never posted at the moment they arrive. They wait in a pending stage until the next frame tick, which is a one-cycle strobe that the system sends once every 125 µs. Because the request line can only fall just after a tick, it asserts at most once per frame.

Once the line is low, it stays low until the processor reads the flag register. The read returns the flags and holds them steady for its whole duration. When the read ends, the flags and the request line are cleared. Events that arrive while the read is in progress are not lost. They are also not wiped by the clear: they are held aside and become the new flag contents when the read ends. They raise the request line only at the following frame tick.

The flag positions follow the event inputs one for one. In the intended use, bit 0 reports a transmit buffer that needs service, bit 1 a receive buffer that is ready, and bit 4 a B-channel buffer that is ready.

Top module: `frame_irq_reg`

## Requirements
- R1: After reset all flags, pending events and held events are zero, `irq_n_o` is 1 and `rd_data_o` is 0.
- R2: An event pulse that arrives while no read is in progress and no tick is present is stored as pending. It does not show up in the flags, and it does not change `irq_n_o`, until a frame tick.
- R3: On a tick cycle with no read in progress, the pending events and any events in that same cycle are ORed into the flags, and the pending stage is emptied. In the next cycle `irq_n_o` is 0 if any flag is set.
- R4: `irq_n_o` goes from 1 to 0 only in the cycle after a frame tick, so it asserts at most once per frame.
- R5: Once `irq_n_o` is 0, it stays 0 until a read completes.
- R6: A read is in progress in every cycle where `rd_sel_i` and `rd_strobe_i` are both 1. In those cycles `rd_data_o` shows the flags, and the flags do not change. In all other cycles `rd_data_o` is 0.
- R7: A read completes in the first cycle in which it is no longer in progress. At the clock edge that ends that cycle, the flags are replaced by the held events and `irq_n_o` returns to 1, unless that cycle also carries a tick.
- R8: Events that arrive during a read are held. They become flags when the read completes, and without a tick in the completion cycle `irq_n_o` stays 1 until the next tick.
- R9: A tick that arrives during a read posts nothing. The pending events are kept and posted at the next tick after the read. If the completion cycle carries a tick, the flags become held | pending | that cycle's events, and `irq_n_o` follows R3.
- R10: Flag bit i always reflects event input bit i (bit 0 transmit service, bit 1 receive ready, bit 4 B-channel ready), with no reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVT_W | Event pulses, one per flag bit |
| frame_tick_i | input | 1 | One-cycle strobe every 125 µs frame |
| rd_sel_i | input | 1 | Flag register selected for access |
| rd_strobe_i | input | 1 | Read strobe |
| rd_data_o | output | EVT_W | Flags during a read, 0 otherwise |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with the default width of eight flags. At that width, the bits named in R10 (0, 1 and 4) and the upper bits can each be driven and read back separately. A directed sequence with exact cycle counts covers the main cases: events deferred to a tick, a tick that falls inside a read, and events held across a read and released when it ends. After that, long random runs place ticks, events and multi-cycle reads at random, so that reads ending on a tick cycle and back-to-back reads also occur. In those runs a behavioural model is compared with both outputs on every clock.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_BUSY = 1'b1
  } rd_phase_e;

  typedef enum logic [2:0] {
    ACT_ACCUM        = 3'd0,
    ACT_TICK         = 3'd1,
    ACT_HOLD         = 3'd2,
    ACT_RELEASE      = 3'd3,
    ACT_RELEASE_TICK = 3'd4
  } post_act_e;

  // Chooses what the storage stages do in this cycle.
  function automatic post_act_e choose_act(logic reading, logic ending, logic tick);
    if (reading) return ACT_HOLD;
    if (ending) return tick ? ACT_RELEASE_TICK : ACT_RELEASE;
    if (tick) return ACT_TICK;
    return ACT_ACCUM;
  endfunction

  function automatic logic act_posts(post_act_e a);
    return (a == ACT_TICK) || (a == ACT_RELEASE_TICK);
  endfunction

  function automatic logic act_releases(post_act_e a);
    return (a == ACT_RELEASE) || (a == ACT_RELEASE_TICK);
  endfunction

endpackage

// File: rtl/irq_rd_tracker.sv
module irq_rd_tracker
  import frame_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_sel_i,
  input  logic rd_strobe_i,
  output logic rd_active_o,
  output logic rd_end_o
);

  rd_phase_e phase_q;

  assign rd_active_o = rd_sel_i & rd_strobe_i;
  assign rd_end_o    = (phase_q == RD_BUSY) & ~rd_active_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= RD_IDLE;
    else        phase_q <= rd_active_o ? RD_BUSY : RD_IDLE;
  end

  // R7
  rd_end_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end_o |-> $past(rd_active_o));

endmodule

// File: rtl/irq_evt_stage.sv
module irq_evt_stage
  import frame_irq_pkg::*;
#(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  post_act_e        act_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] pending_o,
  output logic [EVT_W-1:0] held_o
);

  for (genvar b = 0; b < EVT_W; b++) begin : g_bit
    logic pend_q;
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        held_q <= 1'b0;
      end else begin
        unique case (act_i)
          ACT_HOLD: held_q <= held_q | evt_i[b];
          ACT_ACCUM: pend_q <= pend_q | evt_i[b];
          ACT_TICK: pend_q <= 1'b0;
          ACT_RELEASE: begin
            pend_q <= pend_q | evt_i[b];
            held_q <= 1'b0;
          end
          ACT_RELEASE_TICK: begin
            pend_q <= 1'b0;
            held_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end

    assign pending_o[b] = pend_q;
    assign held_o[b]    = held_q;
  end

  // R9
  pending_kept_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_HOLD) |=> $stable(pending_o));

  // R8
  held_empty_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_releases(act_i) |=> (held_o == '0));

endmodule

// File: rtl/irq_post_reg.sv
module irq_post_reg
  import frame_irq_pkg::*;
#(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  post_act_e        act_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] pending_i,
  input  logic [EVT_W-1:0] held_i,
  output logic [EVT_W-1:0] flags_o,
  output logic             irq_n_o
);

  logic [EVT_W-1:0] flags_q;
  logic [EVT_W-1:0] flags_d;
  logic             irq_n_q;
  logic             irq_n_d;
  logic             post_w;
  logic             release_w;

  assign post_w    = act_posts(act_i);
  assign release_w = act_releases(act_i);

  always_comb begin
    flags_d = flags_q;
    irq_n_d = irq_n_q;
    unique case (act_i)
      ACT_TICK: begin
        flags_d = flags_q | pending_i | evt_i;
        irq_n_d = ~|flags_d;
      end
      ACT_RELEASE: begin
        flags_d = held_i;
        irq_n_d = 1'b1;
      end
      ACT_RELEASE_TICK: begin
        flags_d = held_i | pending_i | evt_i;
        irq_n_d = ~|flags_d;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      flags_q <= flags_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign flags_o = flags_q;
  assign irq_n_o = irq_n_q;

  // R4
  irq_fall_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_q) |-> $past(post_w));

  // R5
  irq_rise_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_q) |-> $past(release_w));

  // R6
  flags_frozen_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_HOLD) |=> $stable(flags_q));

  // R7
  irq_clear_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_RELEASE) |=> irq_n_q);

endmodule

// File: rtl/frame_irq_reg.sv
module frame_irq_reg
  import frame_irq_pkg::*;
#(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             frame_tick_i,
  input  logic             rd_sel_i,
  input  logic             rd_strobe_i,
  output logic [EVT_W-1:0] rd_data_o,
  output logic             irq_n_o
);

  logic             rd_active_w;
  logic             rd_end_w;
  post_act_e        act_w;
  logic [EVT_W-1:0] pending_w;
  logic [EVT_W-1:0] held_w;
  logic [EVT_W-1:0] flags_w;

  irq_rd_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_sel_i   (rd_sel_i),
    .rd_strobe_i(rd_strobe_i),
    .rd_active_o(rd_active_w),
    .rd_end_o   (rd_end_w)
  );

  assign act_w = choose_act(rd_active_w, rd_end_w, frame_tick_i);

  irq_evt_stage #(.EVT_W(EVT_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (act_w),
    .evt_i    (evt_i),
    .pending_o(pending_w),
    .held_o   (held_w)
  );

  irq_post_reg #(.EVT_W(EVT_W)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (act_w),
    .evt_i    (evt_i),
    .pending_i(pending_w),
    .held_i   (held_w),
    .flags_o  (flags_w),
    .irq_n_o  (irq_n_o)
  );

  assign rd_data_o = rd_active_w ? flags_w : '0;

  // R2
  idle_events_not_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w == ACT_ACCUM) |=> $stable(flags_w));

endmodule

// File: tb/tb_frame_irq_reg.sv
`timescale 1ns/1ps
module tb_frame_irq_reg;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt = '0;
  logic         tick = 1'b0;
  logic         sel = 1'b0;
  logic         stb = 1'b0;
  logic [W-1:0] rd_data;
  logic         irq_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  frame_irq_reg #(.EVT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .frame_tick_i(tick),
    .rd_sel_i(sel), .rd_strobe_i(stb), .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  // Behavioural reference model
  int  m_flags, m_pend, m_held;
  bit  m_irq_n, m_in_read;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_pend = 0; m_held = 0; m_irq_n = 1; m_in_read = 0;
    end else begin
      int e;
      e = int'(evt);
      if (sel && stb) begin
        m_held = m_held | e;
        m_in_read = 1;
      end else if (m_in_read) begin
        m_in_read = 0;
        if (tick) begin
          m_flags = m_held | m_pend | e;
          m_pend = 0;
          m_irq_n = (m_flags == 0);
        end else begin
          m_flags = m_held;
          m_pend = m_pend | e;
          m_irq_n = 1;
        end
        m_held = 0;
      end else if (tick) begin
        m_flags = m_flags | m_pend | e;
        m_pend = 0;
        if (m_flags != 0) m_irq_n = 0;
      end else begin
        m_pend = m_pend | e;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check("R6/R10 model rd_data", int'(rd_data), (sel && stb) ? m_flags : 0);
      check("R3/R4/R5/R7 model irq_n", int'(irq_n), int'(m_irq_n));
    end
  end

  task automatic cyc(input logic [W-1:0] e, input bit t, input bit s, input bit b);
    @(posedge clk); #1;
    evt = e; tick = t; sel = s; stb = b;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_n in reset", int'(irq_n), 1);
    check("R1 rd_data in reset", int'(rd_data), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cmp_en = 1;
    cyc(8'h00, 0, 1, 1);
    check("R1 flags after reset", int'(rd_data), 0);
    cyc(8'h00, 0, 0, 0);
    cyc(8'h00, 0, 0, 0);
    check("R1 irq_n after reset", int'(irq_n), 1);

    // R2 idle event stays pending
    cyc(8'h01, 0, 0, 0);
    cyc(8'h00, 0, 0, 0);
    cyc(8'h00, 0, 0, 0);
    check("R2 irq_n before tick", int'(irq_n), 1);

    // R3 tick posts pending plus same-cycle event
    cyc(8'h10, 1, 0, 0);
    check("R3 irq_n in tick cycle", int'(irq_n), 1);
    cyc(8'h00, 0, 0, 0);
    check("R3 irq_n after tick", int'(irq_n), 0);
    cyc(8'h02, 0, 0, 0);          // pending 0x02
    cyc(8'h00, 0, 1, 0);
    check("R6 rd_data with strobe low", int'(rd_data), 0);

    // R6/R10 read shows flags bit0 and bit4
    cyc(8'h04, 0, 1, 1);
    check("R10 rd_data flags", int'(rd_data), 8'h11);
    // R9 tick inside read
    cyc(8'h00, 1, 1, 1);
    check("R6 flags stable in read", int'(rd_data), 8'h11);
    check("R5 irq_n held during read", int'(irq_n), 0);
    cyc(8'h00, 0, 0, 0);          // read completes here
    check("R5 irq_n until completion", int'(irq_n), 0);
    cyc(8'h00, 0, 0, 0);
    check("R7 irq_n after read", int'(irq_n), 1);
    cyc(8'h00, 0, 0, 0);
    check("R8 irq_n waits for tick", int'(irq_n), 1);
    cyc(8'h00, 1, 0, 0);
    cyc(8'h00, 0, 0, 0);
    check("R9 irq_n at tick after read", int'(irq_n), 0);
    cyc(8'h00, 0, 1, 1);
    check("R8/R9 held plus pending", int'(rd_data), 8'h06);
    // R9 completion cycle with tick
    cyc(8'h80, 0, 1, 1);
    cyc(8'h01, 1, 0, 0);
    cyc(8'h00, 0, 0, 0);
    check("R9 irq_n on completion tick", int'(irq_n), 0);
    cyc(8'h00, 0, 1, 1);
    check("R9 completion tick flags", int'(rd_data), 8'h81);
    cyc(8'h00, 0, 0, 0);
    cyc(8'h00, 0, 0, 0);
    check("R7 irq_n cleared", int'(irq_n), 1);

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      logic [W-1:0] e;
      bit t, rs;
      e  = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
      t  = ($urandom_range(0, 11) == 0);
      rs = ($urandom_range(0, 5) < 2);
      cyc(e, t, rs | ($urandom_range(0, 7) == 0), rs);
    end

    cmp_en = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule